// File: doc/BRIEF.md
# Two-Sided Mailbox and Doorbell Unit

This block lets a host processor on a system bus and a local embedded processor signal each other through a shared set of registers. Each side has its own simple register port, with a write strobe, a word address, write data and combinational read data. Traffic towards the local processor is called inbound. It uses two inbound message words and an inbound doorbell. Traffic towards the host is called outbound. It uses two outbound message words and an outbound doorbell. Each direction also has a sticky status register, a mask register and one registered interrupt line.

Both ports use the same word map, and the byte offset of a word is four times its index. Index 0 and 1 hold inbound message 0 and 1. Index 2 and 3 hold outbound message 0 and 1. Index 4 is the inbound doorbell and index 5 the outbound doorbell. Index 6 is the status register of the direction the port receives: inbound for the local port, outbound for the host port. Index 7 is the mask register for that same direction.

Four local event inputs feed the inbound status:
- `l_evt[0]`: machine check.
- `l_evt[1]`: post queue.
- `l_evt[2]`: inbound post overflow.
- `l_evt[3]`: outbound free overflow.

One host event input feeds the outbound post-queue bit. These event inputs come from a queue engine that lies outside this block.

Top module: `msg_doorbell_unit`

## Requirements
- R1: After reset, every message word, both doorbells, both status registers and both interrupts are 0. Index 7 reads 0x1BB on the local port and 0x2B on the host port, so every implemented mask bit is 1.
- R2: A host write to index n (n = 0 or 1) stores inbound message n and sets inbound status bit n. A local write to index 2+n stores outbound message n and sets outbound status bit n. Both ports read the message words back at the same index.
- R3: A host write to index 4 ORs its data into the inbound doorbell. A local write to index 4 clears the doorbell bits where the data holds a 1. Both ports read the inbound doorbell at index 4.
- R4: A local write to index 5 ORs only data bits 28:0 into the outbound doorbell, so bits 31:29 always read 0. A host write to index 5 clears the bits where the data holds a 1.
- R5: Status bit 3 of each direction equals the OR of all bits of that direction's doorbell. It drops only once every doorbell bit is clear, and writing the status register does not clear it.
- R6: A one-cycle pulse on `l_evt[j]` sets inbound status bit 4, 5, 7 or 8 (for j = 0, 1, 2, 3). A pulse on `h_evt` sets outbound status bit 5. These bits stay set after the pulse ends.
- R7: Index 6 reads the raw status ANDed with the mask register. Writing 1s to index 6 clears the sticky bits: 0, 1, 4, 5, 7 and 8 inbound, and 0, 1 and 5 outbound. If a set and a clear hit the same bit in the same cycle, the set wins.
- R8: Index 7 is read/write and holds only the implemented bits. These are 0x1BB inbound (bits 0, 1, 3, 4, 5, 7, 8) and 0x2B outbound (bits 0, 1, 3, 5). All other bits read 0, and the mask changes only when index 7 is written.
- R9: Each interrupt line is the OR of the raw status bits whose mask bit is 0, registered. It changes on the clock edge after the edge that changed the status or the mask.
- R10: Writes to a message word from the side that does not own it are ignored. Host writes to index 2 and 3 and local writes to index 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 3 | Host word index |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_addr` |
| l_wr | input | 1 | Local write strobe |
| l_addr | input | 3 | Local word index |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data for `l_addr` |
| l_evt | input | 4 | Inbound event pulses (machine check, post queue, inbound post overflow, outbound free overflow) |
| h_evt | input | 1 | Outbound post-queue event pulse |
| h_irq | output | 1 | Interrupt to the host |
| l_irq | output | 1 | Interrupt to the local processor |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 3-bit word index and three reserved outbound doorbell bits. With these values the bench can walk a single 1 through all 32 bits of both doorbells, including the reserved top bits. It can also step through every implemented status bit of both directions, one at a time, with its mask cleared and set. Each step checks the read-through-mask value, the set-over-clear priority and the exact cycle of the interrupt edge.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  // word indices shared by both ports
  localparam int IX_IN_MSG  = 0;
  localparam int IX_OUT_MSG = 2;
  localparam int IX_IN_DB   = 4;
  localparam int IX_OUT_DB  = 5;
  localparam int IX_STAT    = 6;
  localparam int IX_MASK    = 7;

  // status bit positions
  localparam int SB_MSG0 = 0;
  localparam int SB_MSG1 = 1;
  localparam int SB_DB   = 3;
  localparam int SB_MC   = 4;
  localparam int SB_PQ   = 5;
  localparam int SB_IPO  = 7;
  localparam int SB_OFO  = 8;

  localparam int IN_SW  = 9;
  localparam int OUT_SW = 6;
  localparam logic [IN_SW-1:0]  IN_VALID   = 9'h1BB;
  localparam logic [IN_SW-1:0]  IN_STICKY  = 9'h1B3;
  localparam logic [OUT_SW-1:0] OUT_VALID  = 6'h2B;
  localparam logic [OUT_SW-1:0] OUT_STICKY = 6'h23;
endpackage

// File: rtl/mdu_msg_bank.sv
module mdu_msg_bank #(
  parameter int DW   = 32,
  parameter int NMSG = 2,
  localparam int XW  = (NMSG > 1) ? $clog2(NMSG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [XW-1:0]            wr_idx,
  input  logic [DW-1:0]            wr_data,
  output logic [NMSG-1:0][DW-1:0]  msg,
  output logic [NMSG-1:0]          hit
);
  logic [NMSG-1:0][DW-1:0] msg_q;

  for (genvar i = 0; i < NMSG; i++) begin : g_word
    assign hit[i] = wr_en && (wr_idx == XW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msg_q[i] <= '0;
      else if (hit[i]) msg_q[i] <= wr_data;
    end

    // R2
    msg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == XW'(i)) |=> (msg_q[i] == $past(wr_data)));
  end

  assign msg = msg_q;
endmodule

// File: rtl/mdu_doorbell.sv
module mdu_doorbell #(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] SET_MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [DW-1:0] set_data,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_data,
  output logic [DW-1:0] db,
  output logic          any
);
  logic [DW-1:0] db_q, db_d;

  always_comb begin
    db_d = db_q;
    if (clr_en) db_d = db_d & ~clr_data;
    if (set_en) db_d = db_d | (set_data & SET_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               db_q <= '0;
    else if (set_en || clr_en) db_q <= db_d;
  end

  assign db  = db_q;
  assign any = |db_q;

  // R3
  db_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((db_q & $past(db_q)) == $past(db_q)));
  // R3
  db_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((db_q & $past(set_data & SET_MASK)) == $past(set_data & SET_MASK)));
endmodule

// File: rtl/mdu_irq_stat.sv
module mdu_irq_stat #(
  parameter int            SW     = 9,
  parameter logic [SW-1:0] VALID  = '1,
  parameter logic [SW-1:0] STICKY = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] ev_set,
  input  logic [SW-1:0] live,
  input  logic          clr_en,
  input  logic [SW-1:0] clr_data,
  input  logic          mask_we,
  input  logic [SW-1:0] mask_wd,
  output logic [SW-1:0] raw,
  output logic [SW-1:0] mask,
  output logic          irq
);
  logic [SW-1:0] sticky_q, sticky_d, mask_q, mask_d;
  logic          irq_q, irq_d;

  always_comb begin
    sticky_d = sticky_q;
    if (clr_en) sticky_d = sticky_d & ~clr_data;
    sticky_d = (sticky_d | ev_set) & STICKY;
    mask_d   = mask_wd & VALID;
    irq_d    = |(raw & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask_q   <= VALID;
      irq_q    <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      if (mask_we) mask_q <= mask_d;
      irq_q <= irq_d;
    end
  end

  assign raw  = (sticky_q | live) & VALID;
  assign mask = mask_q;
  assign irq  = irq_q;

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((sticky_q & $past(clr_data & ~ev_set)) == '0));
  // R6
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_set) |=> ((raw & $past(ev_set & STICKY)) == $past(ev_set & STICKY)));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw & ~mask)) |=> irq);
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(raw & ~mask)) |=> !irq);
endmodule

// File: rtl/msg_doorbell_unit.sv
module msg_doorbell_unit
  import mdu_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 3,
  parameter int RSV_BITS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic [3:0]    l_evt,
  input  logic          h_evt,
  output logic          h_irq,
  output logic          l_irq
);
  localparam int            NMSG     = 2;
  localparam logic [DW-1:0] OUT_SETM = {DW{1'b1}} >> RSV_BITS;

  // word decode
  logic h_in_msg, l_out_msg;
  assign h_in_msg  = h_wr && (h_addr[AW-1:1] == (AW-1)'(IX_IN_MSG / 2));
  assign l_out_msg = l_wr && (l_addr[AW-1:1] == (AW-1)'(IX_OUT_MSG / 2));

  logic [NMSG-1:0][DW-1:0] in_msg, out_msg;
  logic [NMSG-1:0]         in_hit, out_hit;

  mdu_msg_bank #(.DW(DW), .NMSG(NMSG)) u_in_msg (
    .clk, .rst_n, .wr_en(h_in_msg), .wr_idx(h_addr[0]), .wr_data(h_wdata),
    .msg(in_msg), .hit(in_hit));

  mdu_msg_bank #(.DW(DW), .NMSG(NMSG)) u_out_msg (
    .clk, .rst_n, .wr_en(l_out_msg), .wr_idx(l_addr[0]), .wr_data(l_wdata),
    .msg(out_msg), .hit(out_hit));

  logic [DW-1:0] in_db, out_db;
  logic          in_db_any, out_db_any;

  mdu_doorbell #(.DW(DW), .SET_MASK({DW{1'b1}})) u_in_db (
    .clk, .rst_n,
    .set_en(h_wr && h_addr == AW'(IX_IN_DB)), .set_data(h_wdata),
    .clr_en(l_wr && l_addr == AW'(IX_IN_DB)), .clr_data(l_wdata),
    .db(in_db), .any(in_db_any));

  mdu_doorbell #(.DW(DW), .SET_MASK(OUT_SETM)) u_out_db (
    .clk, .rst_n,
    .set_en(l_wr && l_addr == AW'(IX_OUT_DB)), .set_data(l_wdata),
    .clr_en(h_wr && h_addr == AW'(IX_OUT_DB)), .clr_data(h_wdata),
    .db(out_db), .any(out_db_any));

  // status sources
  logic [IN_SW-1:0]  in_ev, in_live, in_raw, in_mask;
  logic [OUT_SW-1:0] out_ev, out_live, out_raw, out_mask;

  always_comb begin
    in_ev          = '0;
    in_ev[SB_MSG0] = in_hit[0];
    in_ev[SB_MSG1] = in_hit[1];
    in_ev[SB_MC]   = l_evt[0];
    in_ev[SB_PQ]   = l_evt[1];
    in_ev[SB_IPO]  = l_evt[2];
    in_ev[SB_OFO]  = l_evt[3];
    in_live        = '0;
    in_live[SB_DB] = in_db_any;
    out_ev          = '0;
    out_ev[SB_MSG0] = out_hit[0];
    out_ev[SB_MSG1] = out_hit[1];
    out_ev[SB_PQ]   = h_evt;
    out_live        = '0;
    out_live[SB_DB] = out_db_any;
  end

  mdu_irq_stat #(.SW(IN_SW), .VALID(IN_VALID), .STICKY(IN_STICKY)) u_in_stat (
    .clk, .rst_n, .ev_set(in_ev), .live(in_live),
    .clr_en(l_wr && l_addr == AW'(IX_STAT)), .clr_data(l_wdata[IN_SW-1:0]),
    .mask_we(l_wr && l_addr == AW'(IX_MASK)), .mask_wd(l_wdata[IN_SW-1:0]),
    .raw(in_raw), .mask(in_mask), .irq(l_irq));

  mdu_irq_stat #(.SW(OUT_SW), .VALID(OUT_VALID), .STICKY(OUT_STICKY)) u_out_stat (
    .clk, .rst_n, .ev_set(out_ev), .live(out_live),
    .clr_en(h_wr && h_addr == AW'(IX_STAT)), .clr_data(h_wdata[OUT_SW-1:0]),
    .mask_we(h_wr && h_addr == AW'(IX_MASK)), .mask_wd(h_wdata[OUT_SW-1:0]),
    .raw(out_raw), .mask(out_mask), .irq(h_irq));

  // read muxes
  always_comb begin
    case (int'(h_addr))
      IX_IN_MSG, IX_IN_MSG + 1:   h_rdata = in_msg[h_addr[0]];
      IX_OUT_MSG, IX_OUT_MSG + 1: h_rdata = out_msg[h_addr[0]];
      IX_IN_DB:                   h_rdata = in_db;
      IX_OUT_DB:                  h_rdata = out_db;
      IX_STAT:                    h_rdata = DW'(out_raw & out_mask);
      default:                    h_rdata = DW'(out_mask);
    endcase
    case (int'(l_addr))
      IX_IN_MSG, IX_IN_MSG + 1:   l_rdata = in_msg[l_addr[0]];
      IX_OUT_MSG, IX_OUT_MSG + 1: l_rdata = out_msg[l_addr[0]];
      IX_IN_DB:                   l_rdata = in_db;
      IX_OUT_DB:                  l_rdata = out_db;
      IX_STAT:                    l_rdata = DW'(in_raw & in_mask);
      default:                    l_rdata = DW'(in_mask);
    endcase
  end

  // R4
  out_db_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_db[DW-1 -: RSV_BITS] == '0);
  // R10
  ro_out_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_out_msg |=> $stable(out_msg));
  // R10
  ro_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_in_msg |=> $stable(in_msg));
  // R5
  db_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_raw[SB_DB] == (in_db != '0));
endmodule

// File: tb/msg_doorbell_unit_test.sv
`timescale 1ns/1ps
module msg_doorbell_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_wr, l_wr, h_evt;
  logic [2:0]  h_addr, l_addr;
  logic [31:0] h_wdata, l_wdata, h_rdata, l_rdata;
  logic [3:0]  l_evt;
  logic        h_irq, l_irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  msg_doorbell_unit uut (
    .clk, .rst_n, .h_wr, .h_addr, .h_wdata, .h_rdata,
    .l_wr, .l_addr, .l_wdata, .l_rdata, .l_evt, .h_evt, .h_irq, .l_irq);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic lw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); l_wr = 1'b1; l_addr = a; l_wdata = d;
    @(negedge clk); l_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [31:0] d);
    h_addr = a; #1; d = h_rdata;
  endtask

  task automatic lr(input logic [2:0] a, output logic [31:0] d);
    l_addr = a; #1; d = l_rdata;
  endtask

  // raise inbound status bit b
  task automatic trig_in(input int b);
    case (b)
      0, 1: hw(3'(b), 32'hA5A5_0000 + b);
      3:    hw(3'd4, 32'h0000_0100);
      default: begin
        @(negedge clk);
        l_evt = (b == 4) ? 4'b0001 : (b == 5) ? 4'b0010 : (b == 7) ? 4'b0100 : 4'b1000;
        @(negedge clk); l_evt = 4'b0;
      end
    endcase
  endtask

  task automatic trig_out(input int b);
    case (b)
      0, 1: lw(3'(2 + b), 32'h5A5A_0000 + b);
      3:    lw(3'd5, 32'h0000_0200);
      default: begin
        @(negedge clk); h_evt = 1'b1;
        @(negedge clk); h_evt = 1'b0;
      end
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int in_bits[7]  = '{0, 1, 3, 4, 5, 7, 8};
    int out_bits[4] = '{0, 1, 3, 5};

    rst_n = 1'b0; h_wr = 0; l_wr = 0; h_evt = 0; l_evt = 0;
    h_addr = 0; l_addr = 0; h_wdata = 0; l_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      hr(3'(a), v); chk("R1 host reset read", v, 32'h0);
      lr(3'(a), v); chk("R1 local reset read", v, 32'h0);
    end
    hr(3'd7, v); chk("R1 host mask reset", v, 32'h2B);
    lr(3'd7, v); chk("R1 local mask reset", v, 32'h1BB);
    chk("R1 irq reset", {30'b0, h_irq, l_irq}, 32'h0);

    // R2 / R7 message words and sticky status
    for (int n = 0; n < 2; n++) begin
      for (int p = 0; p < 4; p++) begin
        v2 = 32'h1357_9BDF * (p + 1) ^ (n << 20);
        hw(3'(n), v2);
        lr(3'(n), v); chk("R2 inbound message", v, v2);
        lr(3'd6, v); chk("R2 inbound status set", v, 32'(1 << n));
        lw(3'd6, 32'(1 << n));
        lr(3'd6, v); chk("R7 inbound status clear", v, 32'h0);
        lw(3'(2 + n), ~v2);
        hr(3'(2 + n), v); chk("R2 outbound message", v, ~v2);
        hr(3'd6, v); chk("R2 outbound status set", v, 32'(1 << n));
        hw(3'd6, 32'(1 << n));
        hr(3'd6, v); chk("R7 outbound status clear", v, 32'h0);
      end
    end

    // R10 ignored writes from the wrong side
    lr(3'd0, v2);
    lw(3'd0, 32'hDEAD_BEEF);
    lr(3'd0, v); chk("R10 local write to inbound msg ignored", v, v2);
    lr(3'd6, v); chk("R10 inbound status untouched", v, 32'h0);
    hr(3'd3, v2);
    hw(3'd3, 32'hFEED_F00D);
    hr(3'd3, v); chk("R10 host write to outbound msg ignored", v, v2);
    hr(3'd6, v); chk("R10 outbound status untouched", v, 32'h0);

    // R3 / R5 inbound doorbell walk
    for (int i = 0; i < 32; i++) begin
      hw(3'd4, 32'(1) << i);
      lr(3'd4, v); chk("R3 inbound doorbell set", v, 32'(1) << i);
      lw(3'd6, 32'h8);
      lr(3'd6, v); chk("R5 doorbell status survives W1C", v, 32'h8);
      lw(3'd4, 32'(1) << i);
      lr(3'd4, v); chk("R3 inbound doorbell clear", v, 32'h0);
      lr(3'd6, v); chk("R5 doorbell status drops", v, 32'h0);
    end
    hw(3'd4, 32'h5);
    lw(3'd4, 32'h1);
    lr(3'd6, v); chk("R5 partial clear keeps status", v, 32'h8);
    lr(3'd4, v); chk("R3 partial clear", v, 32'h4);
    lw(3'd4, 32'h4);
    lr(3'd6, v); chk("R5 full clear", v, 32'h0);

    // R4 outbound doorbell walk incl. reserved bits
    for (int i = 0; i < 32; i++) begin
      lw(3'd5, 32'(1) << i);
      hr(3'd5, v); chk("R4 outbound doorbell set", v, (i < 29) ? (32'(1) << i) : 32'h0);
      hr(3'd6, v); chk("R5 outbound doorbell status", v, (i < 29) ? 32'h8 : 32'h0);
      hw(3'd5, 32'hFFFF_FFFF);
      hr(3'd5, v); chk("R4 outbound doorbell clear", v, 32'h0);
    end

    // R6 event inputs
    for (int j = 0; j < 4; j++) begin
      trig_in(in_bits[3 + j]);
      repeat (2) @(negedge clk);
      lr(3'd6, v); chk("R6 inbound event sticky", v, 32'(1) << in_bits[3 + j]);
      lw(3'd6, 32'h1FF);
      lr(3'd6, v); chk("R7 inbound event clear", v, 32'h0);
    end
    trig_out(5);
    repeat (2) @(negedge clk);
    hr(3'd6, v); chk("R6 outbound event sticky", v, 32'h20);
    hw(3'd6, 32'h3F);
    hr(3'd6, v); chk("R7 outbound event clear", v, 32'h0);

    // R7 set beats clear in the same cycle
    @(negedge clk);
    h_wr = 1; h_addr = 3'd0; h_wdata = 32'h1111_2222;
    l_wr = 1; l_addr = 3'd6; l_wdata = 32'h1;
    @(negedge clk); h_wr = 0; l_wr = 0;
    lr(3'd6, v); chk("R7 set wins over clear", v, 32'h1);
    lw(3'd6, 32'h1);

    // R8 mask register width
    lw(3'd7, 32'hFFFF_FFFF);
    lr(3'd7, v); chk("R8 inbound mask implemented bits", v, 32'h1BB);
    hw(3'd7, 32'hFFFF_FFFF);
    hr(3'd7, v); chk("R8 outbound mask implemented bits", v, 32'h2B);
    hw(3'd7, 32'h0000_0028);
    hr(3'd7, v); chk("R8 outbound mask write", v, 32'h28);
    hw(3'd7, 32'h2B);

    // R9 exact latency on inbound message 0
    lw(3'd7, 32'h1BA);
    @(negedge clk); h_wr = 1; h_addr = 3'd0; h_wdata = 32'h77;
    @(negedge clk); h_wr = 0;
    chk("R9 irq not yet", {31'b0, l_irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq one cycle later", {31'b0, l_irq}, 32'h1);
    lr(3'd6, v); chk("R7 read hides unmasked source", v, 32'h0);
    lw(3'd6, 32'h1);
    chk("R9 irq held until edge", {31'b0, l_irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq drops", {31'b0, l_irq}, 32'h0);
    lw(3'd7, 32'h1BB);

    // R9 sweep inbound sources
    foreach (in_bits[k]) begin
      lw(3'd7, 32'h1BB & ~(32'(1) << in_bits[k]));
      trig_in(in_bits[k]);
      repeat (2) @(negedge clk);
      chk("R9 inbound irq source", {31'b0, l_irq}, 32'h1);
      lw(3'd7, 32'h1BB);
      @(negedge clk);
      chk("R9 inbound irq masked", {31'b0, l_irq}, 32'h0);
      lw(3'd6, 32'h1FF); lw(3'd4, 32'hFFFF_FFFF);
    end

    // R9 sweep outbound sources
    foreach (out_bits[k]) begin
      hw(3'd7, 32'h2B & ~(32'(1) << out_bits[k]));
      trig_out(out_bits[k]);
      repeat (2) @(negedge clk);
      chk("R9 outbound irq source", {31'b0, h_irq}, 32'h1);
      hw(3'd6, 32'h3F); hw(3'd5, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R9 outbound irq cleared", {31'b0, h_irq}, 32'h0);
      hw(3'd7, 32'h2B);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule